// File: doc/BRIEF.md
# ADC Control Register Front End

This block is the register-mapped control side of a successive-approximation converter that produces one result at a time. A host reaches it through 32-bit word accesses on a small byte-addressed bus. Writing the channel-control word both picks the input channel and starts a conversion. The all-ones channel code instead parks the converter in stop mode. The analog core sits outside the block. It receives a start pulse with a channel number and answers with a done strobe and a data word. A calibration request follows the same pattern, using its own start pulse and done strobe and a pass/fail input.

The block holds a conversion-complete flag. When that flag is set and the channel word's interrupt enable is set, the interrupt line goes high. Reading the result clears the flag. Continuous mode restarts the converter after each completion. When overwriting is disabled, a fresh sample cannot displace a result that has not been read yet. A finished calibration sets the same complete flag, so it raises the same interrupt, and it records its outcome in a separate status bit. Offsets in the map without a dedicated function act as plain storage words.

Top module: `adcif_top`

## Requirements
- R1: After reset the channel word (offset 0x00) reads 0x1F, which is stop code with interrupt enable 0. Status, result, configuration, general control and general status read 0. irq and conv_start are low and conv_stop is high.
- R2: A write to offset 0x00 stores the channel from bits [4:0] and the interrupt enable from bit 7. If the channel is not 0x1F, conv_start pulses high for exactly the next cycle, with conv_chan equal to the written channel.
- R3: A write of channel 0x1F starts nothing, raises conv_stop and abandons any running conversion, so a later conv_done leaves the result and the complete flag unchanged.
- R4: A conv_done during a conversion sets status bit 0 (offset 0x08). irq is high from the cycle after the flag and the enable are both 1, and it is low otherwise.
- R5: Reading the result (offset 0x0C) clears status bit 0, and irq falls one cycle later. A completion in the same cycle as that read takes priority and keeps the flag set.
- R6: Configuration bit 16 (offset 0x14) is the overwrite enable. With it at 0, a completion while status bit 0 is set leaves the result unchanged. With it at 1, the new sample replaces the result.
- R7: With general control bit 6 (offset 0x18) set, each completion issues a new conv_start pulse in the following cycle on the same channel. With it clear, no new start follows.
- R8: Writing 1 to general control bit 7 pulses cal_start once. The bit reads 1 until cal_done arrives, then clears itself and sets status bit 0, so the interrupt path is shared.
- R9: General status bit 1 (offset 0x1C) takes the value of cal_fail at each cal_done that ends a calibration, and holds it until the next one.
- R10: Offsets 0x04, 0x10, 0x20, 0x24, 0x28, 0x2C and 0x30 read back the last word written there. Writes to status, result and general status have no effect.
- R11: Offsets above 0x30, and addresses whose two low bits are not zero, read as 0 and ignore writes.
- R12: rdata is valid in the cycle after rd_en and holds until the next read. The result reads as the conversion data zero-extended to 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for one cycle |
| rd_en | input | 1 | Read strobe for one cycle |
| addr | input | ADDR_W | Byte address of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq | output | 1 | Completion interrupt |
| conv_start | output | 1 | One-cycle conversion start to the analog core |
| conv_chan | output | CHAN_W | Channel to convert |
| conv_stop | output | 1 | Converter held in stop mode |
| conv_done | input | 1 | Conversion finished strobe |
| conv_data | input | DATA_W | Conversion data, valid with conv_done |
| cal_start | output | 1 | One-cycle calibration start |
| cal_done | input | 1 | Calibration finished strobe |
| cal_fail | input | 1 | Calibration outcome, valid with cal_done |

## Verification
The assertions run on every cycle and cover the following: a channel write starts or stops the core in the next cycle, a completion while converting always sets the flag, a blocked overwrite keeps the result stable, and a calibration pending bit is always present with its start pulse and drops when its done strobe arrives. Other behaviours can only be shown by the bench's scenarios. These are the interrupt timing relative to a result read, the continuous restart, the latching of the fail bit, and storage and unmapped reads. The same applies to the randomized mix of overwrite settings, channels, data and skipped reads, all checked against a bench model of the result and flag.

// File: rtl/adcif_pkg.sv
package adcif_pkg;
  localparam int OFS_HC   = 'h00;
  localparam int OFS_STAT = 'h08;
  localparam int OFS_RES  = 'h0C;
  localparam int OFS_CFG  = 'h14;
  localparam int OFS_GC   = 'h18;
  localparam int OFS_GS   = 'h1C;
  localparam int OFS_LAST = 'h30;

  localparam int BIT_IE   = 7;
  localparam int BIT_OVW  = 16;
  localparam int BIT_CONT = 6;
  localparam int BIT_CAL  = 7;
  localparam int BIT_CALF = 1;

  typedef enum logic [2:0] {
    RS_ZERO, RS_HC, RS_STAT, RS_RES, RS_CFG, RS_GC, RS_GS, RS_STORE
  } rsel_e;
endpackage

// File: rtl/adcif_decode.sv
module adcif_decode
  import adcif_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic [ADDR_W-1:0] addr,
  output rsel_e             sel
);
  logic aligned;
  logic in_range;

  assign aligned  = (addr[1:0] == 2'b00);
  assign in_range = (int'(addr) <= OFS_LAST);

  always_comb begin
    sel = RS_ZERO;
    if (aligned && in_range) begin
      case (int'(addr))
        OFS_HC:   sel = RS_HC;
        OFS_STAT: sel = RS_STAT;
        OFS_RES:  sel = RS_RES;
        OFS_CFG:  sel = RS_CFG;
        OFS_GC:   sel = RS_GC;
        OFS_GS:   sel = RS_GS;
        default:  sel = RS_STORE;
      endcase
    end
  end
endmodule

// File: rtl/adcif_store.sv
module adcif_store #(
  parameter int NWORDS = 13,
  localparam int IDX_W = $clog2(NWORDS)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [31:0]      wdata,
  input  logic             re,
  input  logic [IDX_W-1:0] ridx,
  output logic [31:0]      rdata
);
  logic [31:0] mem [NWORDS];

  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdata;
    if (re) rdata <= mem[ridx];
  end
endmodule

// File: rtl/adcif_ctrl.sv
module adcif_ctrl
  import adcif_pkg::*;
#(
  parameter int CHAN_W = 5,
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hc_we,
  input  logic              cfg_we,
  input  logic              gc_we,
  input  logic              res_rd,
  input  logic [31:0]       wdata,
  input  logic              conv_done,
  input  logic [DATA_W-1:0] conv_data,
  input  logic              cal_done,
  input  logic              cal_fail,
  output logic [CHAN_W-1:0] chan,
  output logic              ie,
  output logic [31:0]       cfg,
  output logic [31:0]       gc,
  output logic              coco,
  output logic [DATA_W-1:0] res,
  output logic              calf,
  output logic              busy,
  output logic              irq,
  output logic              conv_start,
  output logic              cal_start,
  output logic              conv_stop
);
  localparam logic [CHAN_W-1:0] STOP = '1;

  logic [CHAN_W-1:0] wchan;
  logic conv_fin, cal_fin, take;

  assign wchan    = wdata[CHAN_W-1:0];
  assign conv_fin = conv_done & busy;
  assign cal_fin  = cal_done & gc[BIT_CAL];
  assign take     = conv_fin & (~coco | cfg[BIT_OVW]);

  always_ff @(posedge clk) begin
    if (rst) begin
      chan       <= STOP;
      ie         <= 1'b0;
      cfg        <= '0;
      gc         <= '0;
      coco       <= 1'b0;
      res        <= '0;
      calf       <= 1'b0;
      busy       <= 1'b0;
      irq        <= 1'b0;
      conv_start <= 1'b0;
      cal_start  <= 1'b0;
      conv_stop  <= 1'b1;
    end else begin
      conv_start <= 1'b0;
      cal_start  <= 1'b0;
      irq        <= coco & ie;

      // channel write is the start (or stop) command
      if (hc_we) begin
        chan       <= wchan;
        ie         <= wdata[BIT_IE];
        busy       <= (wchan != STOP);
        conv_start <= (wchan != STOP);
        conv_stop  <= (wchan == STOP);
      end else if (conv_fin) begin
        if (gc[BIT_CONT]) conv_start <= 1'b1;
        else              busy       <= 1'b0;
      end

      if (cfg_we) cfg <= wdata;

      // calibration request bit is sticky until the core reports back
      if (gc_we) begin
        gc          <= wdata;
        gc[BIT_CAL] <= gc[BIT_CAL] | wdata[BIT_CAL];
        cal_start   <= wdata[BIT_CAL] & ~gc[BIT_CAL];
      end
      if (cal_fin) begin
        gc[BIT_CAL] <= 1'b0;
        calf        <= cal_fail;
      end

      if (take) res <= conv_data;

      if (conv_fin || cal_fin) coco <= 1'b1;
      else if (res_rd)         coco <= 1'b0;
    end
  end
endmodule

// File: rtl/adcif_top.sv
module adcif_top
  import adcif_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int CHAN_W = 5,
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              irq,
  output logic              conv_start,
  output logic [CHAN_W-1:0] conv_chan,
  output logic              conv_stop,
  input  logic              conv_done,
  input  logic [DATA_W-1:0] conv_data,
  output logic              cal_start,
  input  logic              cal_done,
  input  logic              cal_fail
);
  localparam int NWORDS = OFS_LAST / 4 + 1;
  localparam int IDX_W  = $clog2(NWORDS);

  rsel_e sel, sel_q;
  logic hc_we, cfg_we, gc_we, st_we, res_rd;
  logic ie, coco, calf, busy;
  logic [31:0] cfg_w, gc_w, mux, ctl_q, store_q;
  logic [DATA_W-1:0] res;
  logic [IDX_W-1:0] idx;

  adcif_decode #(.ADDR_W(ADDR_W)) u_dec (.addr(addr), .sel(sel));

  assign idx    = addr[IDX_W+1:2];
  assign hc_we  = wr_en && (sel == RS_HC);
  assign cfg_we = wr_en && (sel == RS_CFG);
  assign gc_we  = wr_en && (sel == RS_GC);
  assign st_we  = wr_en && (sel == RS_STORE);
  assign res_rd = rd_en && (sel == RS_RES);

  adcif_ctrl #(.CHAN_W(CHAN_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst(rst), .hc_we(hc_we), .cfg_we(cfg_we), .gc_we(gc_we),
    .res_rd(res_rd), .wdata(wdata), .conv_done(conv_done),
    .conv_data(conv_data), .cal_done(cal_done), .cal_fail(cal_fail),
    .chan(conv_chan), .ie(ie), .cfg(cfg_w), .gc(gc_w), .coco(coco),
    .res(res), .calf(calf), .busy(busy), .irq(irq),
    .conv_start(conv_start), .cal_start(cal_start), .conv_stop(conv_stop)
  );

  adcif_store #(.NWORDS(NWORDS)) u_store (
    .clk(clk), .we(st_we), .widx(idx), .wdata(wdata),
    .re(rd_en && (sel == RS_STORE)), .ridx(idx), .rdata(store_q)
  );

  always_comb begin
    mux = '0;
    case (sel)
      RS_HC: begin
        mux[CHAN_W-1:0] = conv_chan;
        mux[BIT_IE]     = ie;
      end
      RS_STAT: mux[0]          = coco;
      RS_RES:  mux[DATA_W-1:0] = res;
      RS_CFG:  mux             = cfg_w;
      RS_GC:   mux             = gc_w;
      RS_GS:   mux[BIT_CALF]   = calf;
      default: mux             = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= RS_ZERO;
      ctl_q <= '0;
    end else if (rd_en) begin
      sel_q <= sel;
      ctl_q <= mux;
    end
  end

  assign rdata = (sel_q == RS_STORE) ? store_q : ctl_q;
endmodule

// File: rtl/adcif_chk.sv
module adcif_chk
  import adcif_pkg::*;
#(
  parameter int CHAN_W = 5,
  parameter int DATA_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              hc_we,
  input logic [31:0]       wdata,
  input logic              conv_start,
  input logic              conv_stop,
  input logic              conv_done,
  input logic              busy,
  input logic              coco,
  input logic [31:0]       cfg,
  input logic [31:0]       gc,
  input logic [DATA_W-1:0] res,
  input logic              cal_start,
  input logic              cal_done
);
  localparam logic [CHAN_W-1:0] STOP = '1;

  // R2
  start_on_write_chk: assert property (@(posedge clk) disable iff (rst)
    hc_we && (wdata[CHAN_W-1:0] != STOP) |=> conv_start);

  // R3
  stop_code_chk: assert property (@(posedge clk) disable iff (rst)
    hc_we && (wdata[CHAN_W-1:0] == STOP) |=> !conv_start && conv_stop);

  // R4
  flag_on_done_chk: assert property (@(posedge clk) disable iff (rst)
    conv_done && busy |=> coco);

  // R6
  no_overwrite_chk: assert property (@(posedge clk) disable iff (rst)
    conv_done && busy && coco && !cfg[BIT_OVW] |=> $stable(res));

  // R8
  cal_clear_chk: assert property (@(posedge clk) disable iff (rst)
    gc[BIT_CAL] && cal_done |=> !gc[BIT_CAL]);

  // R8
  cal_start_pend_chk: assert property (@(posedge clk) disable iff (rst)
    cal_start |-> gc[BIT_CAL]);
endmodule

bind adcif_top adcif_chk #(.CHAN_W(CHAN_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .hc_we(hc_we), .wdata(wdata),
  .conv_start(conv_start), .conv_stop(conv_stop), .conv_done(conv_done),
  .busy(busy), .coco(coco), .cfg(cfg_w), .gc(gc_w), .res(res),
  .cal_start(cal_start), .cal_done(cal_done)
);

// File: tb/adcif_top_bench.sv
`timescale 1ns/1ps
module adcif_top_bench;
  localparam int ADDR_W = 6;
  localparam int CHAN_W = 5;
  localparam int DATA_W = 12;

  logic clk = 1'b0;
  logic rst;
  logic wr_en, rd_en;
  logic [ADDR_W-1:0] addr;
  logic [31:0] wdata, rdata;
  logic irq, conv_start, conv_stop, cal_start;
  logic [CHAN_W-1:0] conv_chan;
  logic conv_done, cal_done, cal_fail;
  logic [DATA_W-1:0] conv_data;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  adcif_top #(.ADDR_W(ADDR_W), .CHAN_W(CHAN_W), .DATA_W(DATA_W)) u_adcif_top (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq), .conv_start(conv_start),
    .conv_chan(conv_chan), .conv_stop(conv_stop), .conv_done(conv_done),
    .conv_data(conv_data), .cal_start(cal_start), .cal_done(cal_done),
    .cal_fail(cal_fail)
  );

  function automatic logic [31:0] zext(input logic [DATA_W-1:0] d);
    return {{(32-DATA_W){1'b0}}, d};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    addr = ADDR_W'(a); wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    addr = ADDR_W'(a); rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic done(input logic [DATA_W-1:0] d);
    conv_data = d; conv_done = 1'b1;
    @(negedge clk);
    conv_done = 1'b0;
  endtask

  task automatic cald(input logic f);
    cal_fail = f; cal_done = 1'b1;
    @(negedge clk);
    cal_done = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [DATA_W-1:0] exp_res;
    logic exp_coco;
    logic [31:0] stw [7];
    int ofs [7];
    ofs = '{'h04, 'h10, 'h20, 'h24, 'h28, 'h2C, 'h30};
    void'($urandom(32'd4242));
    rst = 1'b1; wr_en = 0; rd_en = 0; addr = '0; wdata = '0;
    conv_done = 0; conv_data = '0; cal_done = 0; cal_fail = 0;
    idle(3);
    rst = 1'b0;
    idle(1);

    // R1 reset state
    rd('h00, v); chk("R1 hc", v, 32'h1F);
    rd('h08, v); chk("R1 stat", v, 0);
    rd('h0C, v); chk("R1 res", v, 0);
    rd('h14, v); chk("R1 cfg", v, 0);
    rd('h18, v); chk("R1 gc", v, 0);
    rd('h1C, v); chk("R1 gs", v, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 start", {31'b0, conv_start}, 0);
    chk("R1 stop", {31'b0, conv_stop}, 1);

    // R2 start pulse
    wr('h00, 32'h85);
    chk("R2 start", {31'b0, conv_start}, 1);
    chk("R2 chan", {27'b0, conv_chan}, 5);
    chk("R2 stop low", {31'b0, conv_stop}, 0);
    idle(1);
    chk("R2 pulse width", {31'b0, conv_start}, 0);
    rd('h00, v); chk("R2 readback", v, 32'h85);

    // R4 completion, R12 zero-extension, irq timing
    done(12'hFFF);
    rd('h08, v); chk("R4 flag", v, 1);
    chk("R4 irq", {31'b0, irq}, 1);
    rd('h0C, v); chk("R12 res zext", v, 32'h0000_0FFF);
    // R5 read clears flag, irq falls next cycle
    idle(1);
    chk("R5 irq low", {31'b0, irq}, 0);
    rd('h08, v); chk("R5 flag clear", v, 0);

    // R3 stop code abandons conversion
    wr('h00, 32'h82);
    wr('h00, 32'h9F);
    chk("R3 no start", {31'b0, conv_start}, 0);
    chk("R3 stop high", {31'b0, conv_stop}, 1);
    done(12'h123);
    rd('h08, v); chk("R3 flag stays", v, 0);
    rd('h0C, v); chk("R3 res kept", v, 32'hFFF);

    // R4 enable off: flag without irq
    wr('h00, 32'h02);
    done(12'h0AA);
    idle(2);
    chk("R4 irq masked", {31'b0, irq}, 0);
    rd('h08, v); chk("R4 flag masked", v, 1);

    // R6 overwrite disabled: result kept
    wr('h00, 32'h03);
    done(12'h0BB);
    rd('h0C, v); chk("R6 protected", v, zext(12'h0AA));
    // R6 overwrite enabled
    wr('h14, 32'h0001_0000);
    wr('h00, 32'h03);
    done(12'h0CC);
    wr('h00, 32'h03);
    done(12'h0DD);
    rd('h0C, v); chk("R6 overwrite", v, zext(12'h0DD));

    // R5 done in same cycle as result read keeps flag
    wr('h00, 32'h04);
    addr = ADDR_W'('h0C); rd_en = 1'b1; conv_data = 12'h055; conv_done = 1'b1;
    @(negedge clk);
    rd_en = 1'b0; conv_done = 1'b0;
    rd('h08, v); chk("R5 done wins", v, 1);
    rd('h0C, v); chk("R5 new res", v, zext(12'h055));

    // R7 continuous mode
    wr('h18, 32'h40);
    wr('h00, 32'h06);
    idle(1);
    done(12'h111);
    chk("R7 restart", {31'b0, conv_start}, 1);
    chk("R7 chan", {27'b0, conv_chan}, 6);
    wr('h18, 32'h00);
    done(12'h222);
    chk("R7 no restart", {31'b0, conv_start}, 0);
    rd('h0C, v);

    // R8 / R9 calibration
    wr('h00, 32'h9F);
    wr('h00, 32'h1F | 32'h80);
    wr('h18, 32'h80);
    chk("R8 cal start", {31'b0, cal_start}, 1);
    idle(1);
    chk("R8 cal pulse", {31'b0, cal_start}, 0);
    rd('h18, v); chk("R8 pending", v, 32'h80);
    rd('h08, v); chk("R8 no flag yet", v, 0);
    cald(1'b1);
    rd('h18, v); chk("R8 self clear", v, 0);
    rd('h08, v); chk("R8 flag", v, 1);
    chk("R8 irq", {31'b0, irq}, 1);
    rd('h1C, v); chk("R9 fail", v, 32'h2);
    cald(1'b0);
    rd('h1C, v); chk("R9 ignored idle done", v, 32'h2);
    wr('h18, 32'h80);
    cald(1'b0);
    rd('h1C, v); chk("R9 pass", v, 0);
    rd('h0C, v);
    exp_res = 12'h222;
    chk("R8 res untouched", v, zext(exp_res));

    // R10 storage words and read-only registers
    foreach (stw[i]) begin
      stw[i] = $urandom;
      wr(ofs[i], stw[i]);
    end
    foreach (stw[i]) begin
      rd(ofs[i], v); chk("R10 storage", v, stw[i]);
    end
    wr('h08, 32'hFFFF_FFFF);
    wr('h0C, 32'hFFFF_FFFF);
    wr('h1C, 32'hFFFF_FFFF);
    rd('h08, v); chk("R10 stat ro", v, 0);
    rd('h0C, v); chk("R10 res ro", v, zext(exp_res));
    rd('h1C, v); chk("R10 gs ro", v, 0);

    // R11 unmapped and unaligned
    wr('h34, 32'hDEAD_BEEF);
    rd('h34, v); chk("R11 above map", v, 0);
    rd('h3C, v); chk("R11 top", v, 0);
    wr('h31, 32'h1234_5678);
    rd('h31, v); chk("R11 unaligned", v, 0);
    rd('h30, v); chk("R11 no alias", v, stw[6]);

    // R6 / R5 randomized mix
    exp_coco = 1'b0;
    for (int i = 0; i < 40; i++) begin
      logic ovw;
      logic [CHAN_W-1:0] ch;
      logic [DATA_W-1:0] d;
      ovw = 1'($urandom % 2);
      wr('h14, {15'b0, ovw, 16'b0});
      ch = CHAN_W'($urandom % 31);
      wr('h00, {24'b0, 1'b1, 2'b0, ch});
      chk("R2 rand chan", {27'b0, conv_chan}, {27'b0, ch});
      d = DATA_W'($urandom);
      done(d);
      if (!exp_coco || ovw) exp_res = d;
      exp_coco = 1'b1;
      if ($urandom % 2 == 0) begin
        rd('h0C, v); chk("R6 rand res", v, zext(exp_res));
        exp_coco = 1'b0;
      end
      rd('h08, v); chk("R5 rand flag", v, {31'b0, exp_coco});
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule